// File: doc/BRIEF.md
# Dual-Tone Test Signal Generator

This block produces a synthetic test signal for one DAC channel. Two phase accumulators, one per tone, each run at their own frequency word. The upper bits of each phase drive a pipelined CORDIC rotator that yields the sine of that phase. Each sine is multiplied by its own 16-bit scale. The two products are added with one guard bit, then rounded, saturated and emitted as a single 12-bit sample.

A synchronisation strobe restarts both tones together from their programmed start phases and latches their frequency words. While the strobe is high, the output is all zero. Otherwise the accumulators advance, and the output register updates, only on cycles where the valid strobe is high. The sample format is selectable between two's complement and offset binary.

The whole sine and scale pipeline steps on any cycle with valid or sync high, so both tones see the same fixed latency. A holding sync for a full pipeline depth fills the pipeline with the start phases. A build-time switch removes the datapath and ties the output to zero.

Top module: `dds2_tone_gen`

## Requirements
- R1: After reset, with no sync or valid strobe, `sample_out` is 0.
- R2: An edge with `sync_load` high does three things: it writes 12'h000 to `sample_out` (in either format), it loads each tone's phase with its `init_*` value, and it latches `freq_*` as that tone's increment.
- R3: At an edge with `sync_load` low and `sample_valid` high, each tone's phase becomes (phase + latched increment) mod 2^16. At an edge with both strobes low, phase and increment are unchanged.
- R4: At an edge with `sync_load` low and `sample_valid` low, `sample_out` keeps its value.
- R5: Each tone contributes T = 8191·sin(2π·P/8192)·S/65536, where P is the top 13 bits of the tone's phase and S is its unsigned scale. In two's complement, the sample equals round((T_a + T_b)/4) within ±3 LSB.
- R6: The combined value is saturated to the range [-2048, 2047] and never wraps. Two full-scale tones at phase 16'h4000 give 2047, and at 16'h C000 give -2048.
- R7: With `fmt_offset` = 0, the sample is two's complement. With `fmt_offset` = 1, bit 11 of the saturated sample is inverted (offset binary). The format is applied when the output register updates.
- R8: The pipeline advances on each edge where `sample_valid` or `sync_load` is high. A sample written at such an edge comes from the phases held 15 advancing edges earlier (CD_W+1), and this latency is identical for both tones.
- R9: With the DISABLE parameter set, `sample_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sample_valid | input | 1 | Advance strobe: step phases and update output |
| sync_load | input | 1 | Restart both tones, latch frequency words, clear output |
| fmt_offset | input | 1 | 0 two's complement, 1 offset binary |
| scale_a | input | 16 | Unsigned gain of tone A (65536 = unity) |
| scale_b | input | 16 | Unsigned gain of tone B |
| init_a | input | 16 | Start phase of tone A |
| init_b | input | 16 | Start phase of tone B |
| freq_a | input | 16 | Phase increment of tone A |
| freq_b | input | 16 | Phase increment of tone B |
| sample_out | output | 12 | Combined tone sample |

## Verification
Some rules are checked on every cycle. These are the clearing of the output after a sync edge and the holding of the output on idle edges. They also cover the phase and increment registers of both tones: loading on sync, stepping modulo 2^16 on valid, and holding otherwise. The numeric content of the samples can only be shown by the bench scenarios. That covers the sine shape, the per-tone scaling, the saturation of in-phase full-scale tones, offset-binary conversion and the exact 15-edge alignment between phase and sample. The bench compares these against a floating-point reference that steps in lockstep, including runs with gaps in the valid strobe.

// File: rtl/dds2_pkg.sv
package dds2_pkg;

  // Internal CORDIC angle resolution: one full turn equals 2**ANG_W.
  localparam int ANG_W  = 20;
  localparam int MAX_IT = 16;

  // Micro-rotation angle atan(2**-i) expressed in turns * 2**ANG_W.
  function automatic logic [ANG_W-1:0] atan_step(input int i);
    logic [ANG_W-1:0] v;
    case (i)
      0:  v = 20'd131072;
      1:  v = 20'd77376;
      2:  v = 20'd40883;
      3:  v = 20'd20753;
      4:  v = 20'd10417;
      5:  v = 20'd5213;
      6:  v = 20'd2607;
      7:  v = 20'd1304;
      8:  v = 20'd652;
      9:  v = 20'd326;
      10: v = 20'd163;
      11: v = 20'd81;
      12: v = 20'd41;
      13: v = 20'd20;
      14: v = 20'd10;
      15: v = 20'd5;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Start vector pre-divided by the CORDIC gain (~0.607253 = 19898/32768).
  function automatic int cordic_x_start(input int dw);
    return (((1 << (dw - 1)) - 1) * 19898) / 32768;
  endfunction

endpackage

// File: rtl/dds2_phase_acc.sv
module dds2_phase_acc #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_load,
  input  logic            sample_valid,
  input  logic [PH_W-1:0] init_ph,
  input  logic [PH_W-1:0] freq,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] inc_q
);

  logic [PH_W-1:0] phase_d;
  logic [PH_W-1:0] inc_d;

  always_comb begin
    phase_d = phase_q;
    inc_d   = inc_q;
    if (sync_load) begin
      phase_d = init_ph;
      inc_d   = freq;
    end else if (sample_valid) begin
      phase_d = phase_q + inc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      inc_q   <= inc_d;
    end
  end

endmodule

// File: rtl/dds2_cordic_sin.sv
module dds2_cordic_sin
  import dds2_pkg::*;
#(
  parameter int CPH_W = 13,
  parameter int CD_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [CPH_W-1:0] phase_in,
  output logic [CD_W-1:0]  sin_out
);

  localparam int NIT = (CD_W - 1 > MAX_IT) ? MAX_IT : CD_W - 1;
  localparam int XW  = CD_W + 2;
  localparam logic signed [XW-1:0] X_INIT = XW'(cordic_x_start(CD_W));
  localparam logic signed [XW-1:0] Y_MAX  = XW'((1 << (CD_W - 1)) - 1);
  localparam logic signed [XW-1:0] Y_MIN  = -Y_MAX - XW'(1);

  logic signed [XW-1:0]    x_q [0:NIT];
  logic signed [XW-1:0]    y_q [0:NIT];
  logic signed [ANG_W-1:0] z_q [0:NIT];
  logic                    ng_q[0:NIT];
  logic signed [XW-1:0]    x_d [0:NIT];
  logic signed [XW-1:0]    y_d [0:NIT];
  logic signed [ANG_W-1:0] z_d [0:NIT];
  logic                    ng_d[0:NIT];

  logic             fold;
  logic [CPH_W-1:0] ph_fold;
  logic signed [XW-1:0] y_fin;

  // Fold the second and third quadrant onto the fourth and first by
  // subtracting half a turn; the sign is restored at the output.
  always_comb begin
    fold    = phase_in[CPH_W-1] ^ phase_in[CPH_W-2];
    ph_fold = fold ? {~phase_in[CPH_W-1], phase_in[CPH_W-2:0]} : phase_in;
    x_d[0]  = X_INIT;
    y_d[0]  = '0;
    z_d[0]  = $signed({ph_fold, {(ANG_W-CPH_W){1'b0}}});
    ng_d[0] = fold;
    for (int i = 0; i < NIT; i++) begin
      if (z_q[i][ANG_W-1]) begin
        x_d[i+1] = x_q[i] + (y_q[i] >>> i);
        y_d[i+1] = y_q[i] - (x_q[i] >>> i);
        z_d[i+1] = z_q[i] + $signed(atan_step(i));
      end else begin
        x_d[i+1] = x_q[i] - (y_q[i] >>> i);
        y_d[i+1] = y_q[i] + (x_q[i] >>> i);
        z_d[i+1] = z_q[i] - $signed(atan_step(i));
      end
      ng_d[i+1] = ng_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= NIT; k++) begin
        x_q[k]  <= '0;
        y_q[k]  <= '0;
        z_q[k]  <= '0;
        ng_q[k] <= 1'b0;
      end
    end else if (adv_en) begin
      for (int k = 0; k <= NIT; k++) begin
        x_q[k]  <= x_d[k];
        y_q[k]  <= y_d[k];
        z_q[k]  <= z_d[k];
        ng_q[k] <= ng_d[k];
      end
    end
  end

  always_comb begin
    y_fin = ng_q[NIT] ? -y_q[NIT] : y_q[NIT];
    if (y_fin > Y_MAX)      sin_out = CD_W'(Y_MAX);
    else if (y_fin < Y_MIN) sin_out = CD_W'(Y_MIN);
    else                    sin_out = CD_W'(y_fin);
  end

endmodule

// File: rtl/dds2_mix.sv
module dds2_mix #(
  parameter int NT    = 2,
  parameter int CD_W  = 14,
  parameter int SCL_W = 16,
  parameter int OUT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv_en,
  input  logic                       sample_valid,
  input  logic                       sync_load,
  input  logic                       fmt_offset,
  input  logic [NT-1:0][CD_W-1:0]    sin_in,
  input  logic [NT-1:0][SCL_W-1:0]   scale_in,
  output logic [OUT_W-1:0]           sample_out
);

  localparam int GRD  = (NT > 1) ? $clog2(NT) : 1;
  localparam int SW   = CD_W + GRD;
  localparam int DROP = CD_W - OUT_W;
  localparam int PW   = CD_W + SCL_W + 1;
  localparam logic signed [SW:0] MAXV = (SW+1)'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SW:0] MINV = -MAXV - (SW+1)'(1);
  localparam logic signed [SW:0] RND  = (SW+1)'(1 << (DROP - 1));

  logic signed [PW-1:0]    prod_s [NT];
  logic signed [CD_W-1:0]  tone_d [NT];
  logic signed [CD_W-1:0]  tone_q [NT];
  logic signed [SW-1:0]    sum_s;
  logic signed [SW:0]      rnd_s;
  logic signed [OUT_W-1:0] sat_s;
  logic [OUT_W-1:0]        fmt_s;
  logic [OUT_W-1:0]        out_d;

  // Per-tone gain: scale is an unsigned fraction of unity.
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      prod_s[t] = $signed(sin_in[t]) * $signed({1'b0, scale_in[t]});
      tone_d[t] = CD_W'(prod_s[t] >>> SCL_W);
    end
  end

  // Sum with guard bits, round half up, saturate, then format.
  always_comb begin
    sum_s = '0;
    for (int t = 0; t < NT; t++) begin
      sum_s = sum_s + SW'(tone_q[t]);
    end
    rnd_s = ((SW+1)'(sum_s) + RND) >>> DROP;
    if (rnd_s > MAXV)      sat_s = OUT_W'(MAXV);
    else if (rnd_s < MINV) sat_s = OUT_W'(MINV);
    else                   sat_s = OUT_W'(rnd_s);
    fmt_s = fmt_offset ? {~sat_s[OUT_W-1], sat_s[OUT_W-2:0]} : sat_s;
  end

  always_comb begin
    out_d = sample_out;
    if (sync_load)         out_d = '0;
    else if (sample_valid) out_d = fmt_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) tone_q[t] <= '0;
    end else if (adv_en) begin
      for (int t = 0; t < NT; t++) tone_q[t] <= tone_d[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else        sample_out <= out_d;
  end

endmodule

// File: rtl/dds2_tone_gen.sv
module dds2_tone_gen #(
  parameter int PH_W    = 16,
  parameter int CPH_W   = 13,
  parameter int CD_W    = 14,
  parameter int SCL_W   = 16,
  parameter int OUT_W   = 12,
  parameter bit DISABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic             sync_load,
  input  logic             fmt_offset,
  input  logic [SCL_W-1:0] scale_a,
  input  logic [SCL_W-1:0] scale_b,
  input  logic [PH_W-1:0]  init_a,
  input  logic [PH_W-1:0]  init_b,
  input  logic [PH_W-1:0]  freq_a,
  input  logic [PH_W-1:0]  freq_b,
  output logic [OUT_W-1:0] sample_out
);

  localparam int NT = 2;

  logic [PH_W-1:0] phase_a;
  logic [PH_W-1:0] phase_b;
  logic [PH_W-1:0] inc_a;
  logic [PH_W-1:0] inc_b;

  generate
    if (DISABLE) begin : g_off
      assign sample_out = '0;
      assign phase_a    = '0;
      assign phase_b    = '0;
      assign inc_a      = '0;
      assign inc_b      = '0;
    end else begin : g_on
      logic                     adv_en;
      logic [PH_W-1:0]          init_v [NT];
      logic [PH_W-1:0]          freq_v [NT];
      logic [PH_W-1:0]          ph_v   [NT];
      logic [PH_W-1:0]          inc_v  [NT];
      logic [NT-1:0][CD_W-1:0]  sin_v;
      logic [NT-1:0][SCL_W-1:0] scl_v;

      assign adv_en    = sample_valid | sync_load;
      assign init_v[0] = init_a;
      assign init_v[1] = init_b;
      assign freq_v[0] = freq_a;
      assign freq_v[1] = freq_b;
      assign scl_v[0]  = scale_a;
      assign scl_v[1]  = scale_b;
      assign phase_a   = ph_v[0];
      assign phase_b   = ph_v[1];
      assign inc_a     = inc_v[0];
      assign inc_b     = inc_v[1];

      for (genvar t = 0; t < NT; t++) begin : g_tone
        dds2_phase_acc #(.PH_W(PH_W)) u_acc (
          .clk          (clk),
          .rst_n        (rst_n),
          .sync_load    (sync_load),
          .sample_valid (sample_valid),
          .init_ph      (init_v[t]),
          .freq         (freq_v[t]),
          .phase_q      (ph_v[t]),
          .inc_q        (inc_v[t])
        );

        dds2_cordic_sin #(.CPH_W(CPH_W), .CD_W(CD_W)) u_sin (
          .clk      (clk),
          .rst_n    (rst_n),
          .adv_en   (adv_en),
          .phase_in (ph_v[t][PH_W-1 -: CPH_W]),
          .sin_out  (sin_v[t])
        );
      end

      dds2_mix #(.NT(NT), .CD_W(CD_W), .SCL_W(SCL_W), .OUT_W(OUT_W)) u_mix (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_en       (adv_en),
        .sample_valid (sample_valid),
        .sync_load    (sync_load),
        .fmt_offset   (fmt_offset),
        .sin_in       (sin_v),
        .scale_in     (scl_v),
        .sample_out   (sample_out)
      );
    end
  endgenerate

endmodule

// File: rtl/dds2_tone_chk.sv
module dds2_tone_chk #(
  parameter int PH_W    = 16,
  parameter int OUT_W   = 12,
  parameter bit DISABLE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic             sync_load,
  input logic [PH_W-1:0]  init_a,
  input logic [PH_W-1:0]  init_b,
  input logic [PH_W-1:0]  freq_a,
  input logic [PH_W-1:0]  freq_b,
  input logic [PH_W-1:0]  phase_a,
  input logic [PH_W-1:0]  phase_b,
  input logic [PH_W-1:0]  inc_a,
  input logic [PH_W-1:0]  inc_b,
  input logic [OUT_W-1:0] sample_out
);

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load |=> sample_out == '0); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && !sample_valid) |=> $stable(sample_out)); // R4

  generate
    if (DISABLE) begin : g_chk_off
      AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out == '0); // R9
    end else begin : g_chk_on
      AST_PHASE_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |=> (phase_a == $past(init_a)) && (inc_a == $past(freq_a))); // R2

      AST_PHASE_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |=> (phase_b == $past(init_b)) && (inc_b == $past(freq_b))); // R2

      AST_PHASE_STEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_load && sample_valid) |=> phase_a == PH_W'($past(phase_a) + $past(inc_a))); // R3

      AST_PHASE_STEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_load && sample_valid) |=> phase_b == PH_W'($past(phase_b) + $past(inc_b))); // R3

      AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_load && !sample_valid) |=>
          ($stable(phase_a) && $stable(phase_b) && $stable(inc_a) && $stable(inc_b))); // R3
    end
  endgenerate

endmodule

bind dds2_tone_gen dds2_tone_chk #(
  .PH_W    (PH_W),
  .OUT_W   (OUT_W),
  .DISABLE (DISABLE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sync_load    (sync_load),
  .init_a       (init_a),
  .init_b       (init_b),
  .freq_a       (freq_a),
  .freq_b       (freq_b),
  .phase_a      (phase_a),
  .phase_b      (phase_b),
  .inc_a        (inc_a),
  .inc_b        (inc_b),
  .sample_out   (sample_out)
);

// File: tb/tb_dds2_tone_gen.sv
`timescale 1ns/1ps
module tb_dds2_tone_gen;

  localparam int PIPE = 15;   // advancing edges from phase to sample (R8)
  localparam int TOL  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        sync = 1'b0;
  logic        fmt = 1'b0;
  logic [15:0] sc_a = '0, sc_b = '0, in_a = '0, in_b = '0, fq_a = '0, fq_b = '0;
  logic [11:0] out_on;
  logic [11:0] out_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dds2_tone_gen dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(valid), .sync_load(sync),
    .fmt_offset(fmt), .scale_a(sc_a), .scale_b(sc_b), .init_a(in_a),
    .init_b(in_b), .freq_a(fq_a), .freq_b(fq_b), .sample_out(out_on));

  dds2_tone_gen #(.DISABLE(1'b1)) dut_off (
    .clk(clk), .rst_n(rst_n), .sample_valid(valid), .sync_load(sync),
    .fmt_offset(fmt), .scale_a(sc_a), .scale_b(sc_b), .init_a(in_a),
    .init_b(in_b), .freq_a(fq_a), .freq_b(fq_b), .sample_out(out_off));

  // Reference built from the requirements, stepping on the same edges.
  logic [15:0] m_ph_a, m_ph_b, m_inc_a, m_inc_b;
  logic [15:0] m_pa [PIPE];
  logic [15:0] m_pb [PIPE];
  int          m_exp;
  bit          m_exact;
  bit          m_fmt;

  function automatic real tone_val(input logic [15:0] ph, input logic [15:0] sc);
    real ang;
    ang = 6.283185307179586 * real'(ph[15:3]) / 8192.0;
    return 8191.0 * $sin(ang) * real'(sc) / 65536.0;
  endfunction

  function automatic int ref_sample(input logic [15:0] pa, input logic [15:0] pb,
                                    input logic [15:0] sa, input logic [15:0] sb);
    real y;
    int  r;
    y = (tone_val(pa, sa) + tone_val(pb, sb)) / 4.0;
    r = int'($floor(y + 0.5));
    if (r > 2047)  r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph_a <= '0; m_ph_b <= '0; m_inc_a <= '0; m_inc_b <= '0;
      for (int k = 0; k < PIPE; k++) begin
        m_pa[k] <= '0;
        m_pb[k] <= '0;
      end
      m_exp <= 0; m_exact <= 1'b1; m_fmt <= 1'b0;
    end else begin
      if (sync) begin
        m_ph_a <= in_a; m_ph_b <= in_b; m_inc_a <= fq_a; m_inc_b <= fq_b;
      end else if (valid) begin
        m_ph_a <= m_ph_a + m_inc_a;
        m_ph_b <= m_ph_b + m_inc_b;
      end
      if (sync || valid) begin
        m_pa[0] <= m_ph_a;
        m_pb[0] <= m_ph_b;
        for (int k = 1; k < PIPE; k++) begin
          m_pa[k] <= m_pa[k-1];
          m_pb[k] <= m_pb[k-1];
        end
      end
      if (sync) begin
        m_exp <= 0; m_exact <= 1'b1; m_fmt <= 1'b0;
      end else if (valid) begin
        m_exp <= ref_sample(m_pa[PIPE-1], m_pb[PIPE-1], sc_a, sc_b);
        m_exact <= 1'b0;
        m_fmt <= fmt;
      end
    end
  end

  task automatic chk_model(input string req);
    logic signed [11:0] s;
    int act;
    int diff;
    int tol;
    s = m_fmt ? (out_on ^ 12'h800) : out_on;
    act = s;
    diff = act - m_exp;
    tol = m_exact ? 0 : TOL;
    checks++;
    if (diff > tol || diff < -tol) begin
      errors++;
      $display("FAIL %s sample actual %0d expected %0d (tol %0d)", req, act, m_exp, tol);
    end
  endtask

  task automatic chk_exact(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 12'h%03h expected 12'h%03h", req, act, exp);
    end
  endtask

  task automatic run(input int n, input string req, input bit gaps);
    logic [15:0] lf = 16'hACE1;
    bit          hold_prev = 1'b0;
    logic [11:0] prev = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_model(req);
      if (hold_prev) chk_exact("R4", out_on, prev);
      prev = out_on;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      valid = gaps ? lf[0] : 1'b1;
      hold_prev = !valid && !sync;
    end
  endtask

  task automatic do_sync(input int n);
    @(negedge clk);
    sync = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_model("R2");
      chk_exact("R2", out_on, 12'h000);
    end
    sync = 1'b0;
  endtask

  task automatic set_tones(input logic [15:0] ia, input logic [15:0] fa, input logic [15:0] sa,
                           input logic [15:0] ib, input logic [15:0] fb, input logic [15:0] sb);
    @(negedge clk);
    in_a = ia; fq_a = fa; sc_a = sa;
    in_b = ib; fq_b = fb; sc_b = sb;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_exact("R1", out_on, 12'h000);
    chk_exact("R1", out_off, 12'h000);
  endtask

  task automatic t_single;
    set_tones(16'h0000, 16'h0123, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    do_sync(20);
    run(300, "R5", 1'b0);
  endtask

  task automatic t_dual;
    set_tones(16'h1000, 16'h0200, 16'h8000, 16'h8000, 16'h0731, 16'h6000);
    do_sync(20);
    run(400, "R5", 1'b0);
  endtask

  task automatic t_latency;
    set_tones(16'h0000, 16'h4000, 16'hFFFF, 16'h2000, 16'h4000, 16'h0000);
    do_sync(20);
    run(80, "R8", 1'b0);
    set_tones(16'h0800, 16'h1100, 16'h7000, 16'h3000, 16'h2300, 16'h9000);
    do_sync(20);
    run(120, "R8", 1'b1);
  endtask

  task automatic t_saturate;
    set_tones(16'h0000, 16'h0100, 16'hFFFF, 16'h0000, 16'h0100, 16'hFFFF);
    do_sync(20);
    run(300, "R6", 1'b0);
    set_tones(16'h4000, 16'h0000, 16'hFFFF, 16'h4000, 16'h0000, 16'hFFFF);
    do_sync(20);
    run(20, "R6", 1'b0);
    chk_exact("R6", out_on, 12'h7FF);
    set_tones(16'hC000, 16'h0000, 16'hFFFF, 16'hC000, 16'h0000, 16'hFFFF);
    do_sync(20);
    run(20, "R6", 1'b0);
    chk_exact("R6", out_on, 12'h800);
  endtask

  task automatic t_gaps;
    set_tones(16'h0400, 16'h0357, 16'hC000, 16'h9000, 16'h0111, 16'h4000);
    do_sync(20);
    run(500, "R3", 1'b1);
  endtask

  task automatic t_wrap;
    set_tones(16'hFF00, 16'hF3A1, 16'h9000, 16'h7F00, 16'h8001, 16'h5000);
    do_sync(20);
    run(300, "R3", 1'b0);
  endtask

  task automatic t_format;
    @(negedge clk);
    fmt = 1'b1;
    set_tones(16'h4000, 16'h0000, 16'hFFFF, 16'h4000, 16'h0000, 16'hFFFF);
    do_sync(20);
    run(20, "R7", 1'b0);
    chk_exact("R7", out_on, 12'hFFF);
    set_tones(16'hC000, 16'h0000, 16'hFFFF, 16'hC000, 16'h0000, 16'hFFFF);
    do_sync(20);
    run(20, "R7", 1'b0);
    chk_exact("R7", out_on, 12'h000);
    set_tones(16'h0000, 16'h0377, 16'hE000, 16'h5000, 16'h0123, 16'h3000);
    do_sync(20);
    run(300, "R7", 1'b1);
    @(negedge clk);
    fmt = 1'b0;
    run(100, "R7", 1'b0);
  endtask

  task automatic t_reload;
    set_tones(16'h0000, 16'h0456, 16'hA000, 16'h2000, 16'h0222, 16'h6000);
    do_sync(20);
    run(60, "R2", 1'b0);
    set_tones(16'h6000, 16'h0789, 16'hA000, 16'hE000, 16'h0333, 16'h6000);
    do_sync(1);
    run(200, "R2", 1'b0);
  endtask

  task automatic t_disabled;
    set_tones(16'h4000, 16'h0100, 16'hFFFF, 16'h4000, 16'h0100, 16'hFFFF);
    do_sync(20);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      valid = 1'b1;
      chk_exact("R9", out_off, 12'h000);
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_latency();
    t_saturate();
    t_gaps();
    t_wrap();
    t_format();
    t_reload();
    t_disabled();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule